// File: doc/BRIEF.md
# Packed SIMD Halving and Saturating Adder

This block adds or subtracts two 32-bit operands split into independent lanes, in one of four lane formats chosen per operation. The first format treats the operands as two unsigned 16-bit lanes. A wrapping or clamping result is produced in each lane, and a sticky overflow flag records any lane that left its range. The other three formats compute averages. They work on four unsigned bytes, on two signed halfwords, or on one signed word. The sum or difference is formed one bit wider than the lane and then halved, and a half can optionally be rounded upward.

An operation is presented with a valid strobe. Its result and a matching output valid appear on registered outputs after the sampling edge. The result register keeps its value between operations. The overflow flag keeps its value until a separate clear input is raised.

Top module: `packed_halving_adder`

## Requirements
- R1: While `rst` is high at a clock edge, the block sets `res` to 0, `out_vld` to 0 and `ovf` to 0.
- R2: `out_vld` is high in the cycle after an edge at which `in_vld` was high, and low otherwise.
- R3: With `fmt`=0 and `sub`=0, each 16-bit lane (bits 15:0 and bits 31:16) holds the unsigned sum of the matching operand lanes. When that sum exceeds 0xFFFF, the lane takes the low 16 bits if `adj`=0 and takes 0xFFFF if `adj`=1.
- R4: With `fmt`=0 and `sub`=1, each 16-bit lane holds a minus b. When a < b, the lane wraps modulo 2^16 if `adj`=0 and becomes 0 if `adj`=1.
- R5: A sampled `fmt`=0 operation in which any lane goes out of range sets `ovf`. Once set, `ovf` stays high without `flag_clr`. Operations in formats 1, 2 and 3 never set it.
- R6: `flag_clr` high at an edge clears `ovf`. If an overflowing `fmt`=0 operation is sampled at the same edge, `ovf` is set instead.
- R7: With `fmt`=1, each byte lane is (a ± b + `adj`) at 9-bit width, and the lane keeps bits 8:1 of that value.
- R8: With `fmt`=2, each 16-bit lane sign-extends both operands to 17 bits and computes a ± b + `adj`. The lane keeps bits 16:1, which is an arithmetic halving.
- R9: With `fmt`=3, the whole word sign-extends both operands to 33 bits and computes a ± b + `adj`. The result keeps bits 32:1, so it never overflows.
- R10: `res` holds its value across any edge at which `in_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Operands and controls are sampled at this edge |
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| sub | input | 1 | 0 adds, 1 subtracts b from a |
| fmt | input | 2 | Lane format: 0 unsigned 16-bit, 1 unsigned 8-bit halving, 2 signed 16-bit halving, 3 signed 32-bit halving |
| adj | input | 1 | Saturate in format 0, round up in formats 1 to 3 |
| flag_clr | input | 1 | Clears the sticky overflow flag |
| out_vld | output | 1 | Result valid |
| res | output | 32 | Registered lane result |
| ovf | output | 1 | Sticky overflow flag |

## Verification
Every result, together with `out_vld` and the overflow update it causes, is due exactly one edge after the edge that samples `in_vld`. No further latency applies in any format. The bench changes inputs on the falling clock edge. It compares `res`, `out_vld` and `ovf` at the next falling edge, half a cycle after the registers load. The same sampling point is used to confirm that a cycle without `in_vld` leaves `res` unchanged and drops `out_vld`.

// File: rtl/packed_halving_adder.sv
module packed_halving_adder #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_vld,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic [1:0]   fmt,
  input  logic         adj,
  input  logic         flag_clr,
  output logic         out_vld,
  output logic [W-1:0] res,
  output logic         ovf
);
  localparam int H = W / 2;
  localparam int B = W / 4;
  localparam logic [1:0] F_USAT = 2'd0, F_UBYTE = 2'd1, F_SHALF = 2'd2, F_SWORD = 2'd3;

  logic [1:0]   h_ov;
  logic [W-1:0] r_uh, r_ub, r_sh, r_sw, nxt;

  for (genvar g = 0; g < 2; g++) begin : g_half
    wire [H-1:0] x = a[g*H +: H];
    wire [H-1:0] y = b[g*H +: H];
    wire [H:0]   s = sub ? {1'b0, x} - {1'b0, y} : {1'b0, x} + {1'b0, y};
    wire [H:0]   t = (sub ? {x[H-1], x} - {y[H-1], y} : {x[H-1], x} + {y[H-1], y})
                     + {{H{1'b0}}, adj};
    assign h_ov[g] = s[H];
    assign r_uh[g*H +: H] = (s[H] && adj) ? (sub ? {H{1'b0}} : {H{1'b1}}) : s[H-1:0];
    assign r_sh[g*H +: H] = t[H:1];
  end

  for (genvar g = 0; g < 4; g++) begin : g_byte
    wire [B-1:0] x = a[g*B +: B];
    wire [B-1:0] y = b[g*B +: B];
    wire [B:0]   u = (sub ? {1'b0, x} - {1'b0, y} : {1'b0, x} + {1'b0, y})
                     + {{B{1'b0}}, adj};
    assign r_ub[g*B +: B] = u[B:1];
  end

  wire [W:0] wsum = (sub ? {a[W-1], a} - {b[W-1], b} : {a[W-1], a} + {b[W-1], b})
                    + {{W{1'b0}}, adj};
  assign r_sw = wsum[W:1];

  always_comb begin
    case (fmt)
      F_USAT:  nxt = r_uh;
      F_UBYTE: nxt = r_ub;
      F_SHALF: nxt = r_sh;
      default: nxt = r_sw;
    endcase
  end

  wire ov_evt = in_vld && (fmt == F_USAT) && (|h_ov);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      res     <= '0;
      ovf     <= 1'b0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) res <= nxt;
      ovf <= (ovf & ~flag_clr) | ov_evt;
    end
  end

  p_vld_r2: assert property (@(posedge clk) disable iff (rst) in_vld |=> out_vld);
  p_novld_r2: assert property (@(posedge clk) disable iff (rst) !in_vld |=> !out_vld);
  p_hold_r10: assert property (@(posedge clk) disable iff (rst) !in_vld |=> $stable(res));
  p_sticky_r5: assert property (@(posedge clk) disable iff (rst) ovf && !flag_clr |=> ovf);
  p_halve_noflag_r5: assert property (@(posedge clk) disable iff (rst)
    !ovf && !(in_vld && fmt == F_USAT) |=> !ovf);
  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    flag_clr && !(in_vld && fmt == F_USAT) |=> !ovf);
  p_sat_top_r3: assert property (@(posedge clk) disable iff (rst)
    in_vld && fmt == F_USAT && !sub && adj && a[H-1:0] == {H{1'b1}} && b[H-1:0] != '0
    |=> res[H-1:0] == {H{1'b1}} && ovf);
  p_sat_floor_r4: assert property (@(posedge clk) disable iff (rst)
    in_vld && fmt == F_USAT && sub && adj && a[H-1:0] < b[H-1:0]
    |=> res[H-1:0] == '0 && ovf);
endmodule

// File: tb/sim_packed_halving_adder.sv
module sim_packed_halving_adder;
  logic clk = 0, rst = 1, in_vld = 0, sub = 0, adj = 0, flag_clr = 0;
  logic [1:0] fmt = 0;
  logic [31:0] a = 0, b = 0;
  logic out_vld, ovf;
  logic [31:0] res;
  int nvec = 0, nfail = 0;
  logic exp_ovf = 0;

  always #2.5 clk = ~clk;

  packed_halving_adder u0 (.clk(clk), .rst(rst), .in_vld(in_vld), .a(a), .b(b), .sub(sub),
    .fmt(fmt), .adj(adj), .flag_clr(flag_clr), .out_vld(out_vld), .res(res), .ovf(ovf));

  function automatic logic [31:0] pick(int i);
    case (i)
      0: return 32'h0000_0000;  1: return 32'hFFFF_FFFF;  2: return 32'h8000_0000;
      3: return 32'h7FFF_FFFF;  4: return 32'h0001_0001;  5: return 32'hFFFF_0001;
      6: return 32'h8000_7FFF;  7: return 32'h7F80_FF01;  8: return 32'h1234_5678;
      9: return 32'h9ABC_DEF0;  10: return 32'h00FF_00FF; 11: return 32'hFF00_FF00;
      12: return 32'h0101_0101; 13: return 32'h8080_8080; 14: return 32'h7F7F_7F7F;
      default: return 32'hFFFE_0002;
    endcase
  endfunction

  function automatic logic [31:0] model(logic [31:0] x, logic [31:0] y, logic [1:0] f,
                                        logic s, logic m, output logic ev);
    logic [31:0] r = 0;
    ev = 0;
    case (f)
      2'd0: for (int h = 0; h < 2; h++) begin
        int p = int'(x[16*h +: 16]), q = int'(y[16*h +: 16]);
        int v = s ? p - q : p + q;
        logic o = s ? (p < q) : (v > 65535);
        ev |= o;
        r[16*h +: 16] = (o && m) ? (s ? 16'h0 : 16'hFFFF) : 16'(v);
      end
      2'd1: for (int k = 0; k < 4; k++) begin
        int p = int'(x[8*k +: 8]), q = int'(y[8*k +: 8]);
        int v = (s ? p - q : p + q) + int'(m);
        r[8*k +: 8] = 8'(v >>> 1);
      end
      2'd2: for (int h = 0; h < 2; h++) begin
        int p = int'($signed(x[16*h +: 16])), q = int'($signed(y[16*h +: 16]));
        int v = (s ? p - q : p + q) + int'(m);
        r[16*h +: 16] = 16'(v >>> 1);
      end
      default: begin
        longint p = longint'($signed(x)), q = longint'($signed(y));
        longint v = (s ? p - q : p + q) + longint'(m);
        r = 32'(v >>> 1);
      end
    endcase
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] x, logic [31:0] y, logic [1:0] f, logic s, logic m, logic c);
    logic ev;
    logic [31:0] e;
    string req;
    e = model(x, y, f, s, m, ev);
    a = x; b = y; fmt = f; sub = s; adj = m; flag_clr = c; in_vld = 1;
    exp_ovf = (exp_ovf & ~c) | ev;
    @(negedge clk);
    in_vld = 0; flag_clr = 0;
    case (f)
      2'd0: req = s ? "R4" : "R3";
      2'd1: req = "R7";
      2'd2: req = "R8";
      default: req = "R9";
    endcase
    check(res === e, req, res, e);
    check(ovf === exp_ovf, "R5 ovf", 32'(ovf), 32'(exp_ovf));
    check(out_vld === 1'b1, "R2 out_vld", 32'(out_vld), 32'd1);
  endtask

  initial begin
    #1_000_000;
    nfail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    check(res === 0 && out_vld === 0 && ovf === 0, "R1 reset", res, 0);
    rst = 0;
    @(negedge clk);
    check(out_vld === 0, "R2 idle", 32'(out_vld), 0);

    // R3 saturation sets the flag; R6 clear; R6 clear with simultaneous event
    apply(32'hFFFF_0001, 32'h0001_0001, 2'd0, 0, 1, 0);
    flag_clr = 1; @(negedge clk); flag_clr = 0; exp_ovf = 0;
    check(ovf === 0, "R6 clear", 32'(ovf), 0);
    apply(32'h0000_0005, 32'h0000_0006, 2'd0, 1, 1, 1);
    check(ovf === 1, "R6 event beats clear", 32'(ovf), 1);
    flag_clr = 1; @(negedge clk); flag_clr = 0; exp_ovf = 0;

    // R5 halving formats leave the flag low
    for (int f = 1; f < 4; f++) begin
      apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'(f), 0, 1, 0);
      apply(32'h0000_0000, 32'hFFFF_FFFF, 2'(f), 1, 0, 0);
      check(ovf === 0, "R5 halving no flag", 32'(ovf), 0);
    end

    // R10 hold
    held = res;
    a = ~a; b = ~b; @(negedge clk);
    check(res === held, "R10 hold", res, held);
    check(out_vld === 0, "R2 drop", 32'(out_vld), 0);

    // sweep: signed formats first so the flag is exercised from clear by halving
    for (int f = 3; f >= 0; f--)
      for (int s = 0; s < 2; s++)
        for (int m = 0; m < 2; m++)
          for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++)
              apply(pick(i), pick(j), 2'(f), 1'(s), 1'(m), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule